// File: doc/BRIEF.md
# Pipelined Fixed-Point Square Root

This block takes an unsigned 16-bit integer and returns its square root as an unsigned fixed-point number with 8 integer bits and 10 fractional bits. A step of 2^-10 is finer than 0.001. The root is produced digit by digit with a non-restoring recurrence. The operand gets 20 fractional zero bits appended, which gives a 36-bit radicand. Each step takes the next pair of radicand bits. It then adds or subtracts a trial term, chosen by the sign of the running remainder. The remainder is never restored.

All 18 steps are unrolled, and each step has its own register stage. A new operand can be presented on every clock. Its result appears a fixed number of cycles later, with results in input order. Every stage uses only shifts, one adder/subtractor and a 2-way choice. The result is the truncated root: floor(sqrt(x) * 1024).

Top module: `sqrt_pipe`

## Requirements
- R1: For an accepted operand x, `out_root` equals floor(sqrt(x) * 1024) as an 18-bit Q8.10 value. The integer part is in bits 17:10 and the fraction is in bits 9:0.
- R2: An operand presented with `in_valid` high in cycle c produces `out_valid` high with its result in cycle c+18.
- R3: Operands may be presented on every consecutive cycle. Each one yields its own result, on consecutive cycles and in the same order.
- R4: A cycle with `in_valid` low yields a cycle 18 cycles later with `out_valid` low. No result appears that was not requested.
- R5: While the synchronous active-high `rst` is high, operands are not accepted. Every result in flight is discarded. `out_valid` is low from the first edge with `rst` high, and it stays low until a new operand has had its 18 cycles.
- R6: Operand 0 returns 0. Operand 1 returns 1024 (1.0). Operand 65535 returns 262141 (about 255.998).
- R7: A perfect square k*k, for k from 0 to 255, returns exactly k*1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears all valid flags |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 16 | Unsigned integer operand |
| out_valid | output | 1 | Result present this cycle |
| out_root | output | 18 | Truncated root, Q8.10 unsigned |

## Verification
A corrupted remainder or sign in any stage shows up as a wrong output value. It appears the cycle that operand leaves the pipe, at most 18 cycles after the fault. Because the root is formed one bit per stage, a single bad stage usually damages one bit position and every lower bit of the affected results. A lost or extra valid flag shows up as a result in the wrong cycle, or as a missing or extra `out_valid` pulse. The bench compares every cycle's `out_valid` against its own schedule, so a shifted latency is caught on the first operand. Corner values, exact squares, bubbles, back-to-back random operands and a reset in the middle of a stream each target one of these failure modes.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;

    // default operand width and fractional result bits
    localparam int unsigned DEF_IN_W   = 16;
    localparam int unsigned DEF_FRAC_W = 10;

    // action a stage applies to its shifted remainder
    typedef enum logic {
        OP_SUB = 1'b0,
        OP_ADD = 1'b1
    } sqrt_op_e;

endpackage

// File: rtl/sqrt_seed.sv
module sqrt_seed #(
    parameter int unsigned IN_W   = 16,
    parameter int unsigned FRAC_W = 10,
    parameter int unsigned RAD_W  = IN_W + 2 * FRAC_W,
    parameter int unsigned ROOT_W = IN_W / 2 + FRAC_W,
    parameter int unsigned REM_W  = ROOT_W + 4
) (
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              seed_valid,
    output logic [RAD_W-1:0]  seed_rad,
    output logic [REM_W-1:0]  seed_rem,
    output logic [ROOT_W-1:0] seed_root
);

    localparam int unsigned PAD_W = RAD_W - IN_W;

    // operand with fractional zero bits appended; empty remainder and root
    always_comb begin
        seed_valid = in_valid;
        seed_rad   = {in_data, {PAD_W{1'b0}}};
        seed_rem   = '0;
        seed_root  = '0;
    end

endmodule

// File: rtl/sqrt_stage.sv
module sqrt_stage
    import sqrt_pkg::*;
#(
    parameter int unsigned RAD_W  = 36,
    parameter int unsigned ROOT_W = 18,
    parameter int unsigned REM_W  = ROOT_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [RAD_W-1:0]  in_rad,
    input  logic [REM_W-1:0]  in_rem,
    input  logic [ROOT_W-1:0] in_root,
    output logic              out_valid,
    output logic [RAD_W-1:0]  out_rad,
    output logic [REM_W-1:0]  out_rem,
    output logic [ROOT_W-1:0] out_root
);

    typedef struct packed {
        logic              valid;
        logic [RAD_W-1:0]  rad;
        logic [REM_W-1:0]  rem;
        logic [ROOT_W-1:0] root;
    } stage_t;

    stage_t            st_d, st_q;
    sqrt_op_e          op;
    logic [1:0]        pair;
    logic [REM_W-1:0]  shifted;
    logic [REM_W-1:0]  trial;

    always_comb begin
        // sign of the incoming remainder picks the action
        op      = in_rem[REM_W-1] ? OP_ADD : OP_SUB;
        pair    = in_rad[RAD_W-1 -: 2];
        shifted = (in_rem << 2) | REM_W'(pair);
        trial   = '0;
        trial[ROOT_W+1:0] = {in_root, (op == OP_ADD), 1'b1};

        st_d.valid = in_valid;
        st_d.rad   = in_rad << 2;
        st_d.rem   = (op == OP_ADD) ? (shifted + trial) : (shifted - trial);
        st_d.root  = {in_root[ROOT_W-2:0], ~st_d.rem[REM_W-1]};
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (rst) begin
            st_q.valid <= 1'b0;
        end
    end

    assign out_valid = st_q.valid;
    assign out_rad   = st_q.rad;
    assign out_rem   = st_q.rem;
    assign out_root  = st_q.root;

    // remainder window: 0 <= rem <= 2q when positive, -rem <= 2q+1 when negative
    logic [REM_W-1:0] lim_pos, lim_neg, rem_mag;
    always_comb begin
        lim_pos = '0;
        lim_pos[ROOT_W:0] = {st_q.root, 1'b0};
        lim_neg = lim_pos + REM_W'(1);
        rem_mag = -st_q.rem;
    end

    a_r1_rem_window_pos: assert property (@(posedge clk) disable iff (rst)
        (st_q.valid && !st_q.rem[REM_W-1]) |-> (st_q.rem <= lim_pos));

    a_r1_rem_window_neg: assert property (@(posedge clk) disable iff (rst)
        (st_q.valid && st_q.rem[REM_W-1]) |-> (rem_mag <= lim_neg));

endmodule

// File: rtl/sqrt_pipe.sv
module sqrt_pipe
    import sqrt_pkg::*;
#(
    parameter int unsigned IN_W   = DEF_IN_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W,
    parameter int unsigned ROOT_W = IN_W / 2 + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              out_valid,
    output logic [ROOT_W-1:0] out_root
);

    localparam int unsigned STAGES = ROOT_W;
    localparam int unsigned RAD_W  = 2 * ROOT_W;
    localparam int unsigned REM_W  = ROOT_W + 4;
    localparam int unsigned CNT_W  = $clog2(STAGES + 2);

    logic              v_s    [STAGES+1];
    logic [RAD_W-1:0]  rad_s  [STAGES+1];
    logic [REM_W-1:0]  rem_s  [STAGES+1];
    logic [ROOT_W-1:0] root_s [STAGES+1];

    sqrt_seed #(
        .IN_W  (IN_W),
        .FRAC_W(FRAC_W),
        .RAD_W (RAD_W),
        .ROOT_W(ROOT_W),
        .REM_W (REM_W)
    ) u_seed (
        .in_valid  (in_valid),
        .in_data   (in_data),
        .seed_valid(v_s[0]),
        .seed_rad  (rad_s[0]),
        .seed_rem  (rem_s[0]),
        .seed_root (root_s[0])
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        sqrt_stage #(
            .RAD_W (RAD_W),
            .ROOT_W(ROOT_W),
            .REM_W (REM_W)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_valid (v_s[g]),
            .in_rad   (rad_s[g]),
            .in_rem   (rem_s[g]),
            .in_root  (root_s[g]),
            .out_valid(v_s[g+1]),
            .out_rad  (rad_s[g+1]),
            .out_rem  (rem_s[g+1]),
            .out_root (root_s[g+1])
        );
    end

    assign out_valid = v_s[STAGES];
    assign out_root  = root_s[STAGES];

    // in-flight operand count, kept apart from the valid chain
    logic [CNT_W-1:0] fly_d, fly_q;
    always_comb begin
        fly_d = fly_q + CNT_W'(in_valid) - CNT_W'(out_valid);
    end
    always_ff @(posedge clk) begin
        if (rst) fly_q <= '0;
        else     fly_q <= fly_d;
    end

    logic [REM_W-1:0] fin_lim, fin_mag;
    always_comb begin
        fin_lim = '0;
        fin_lim[ROOT_W:0] = {out_root, 1'b0};
        fin_mag = -rem_s[STAGES];
    end

    a_r3_fly_bound: assert property (@(posedge clk) disable iff (rst)
        fly_q <= CNT_W'(STAGES));

    a_r4_no_phantom: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (fly_q != '0));

    a_r5_reset_drains: assert property (@(posedge clk)
        rst |=> !out_valid);

    a_r1_digits_used: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rad_s[STAGES] == '0));

    a_r1_final_window: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rem_s[STAGES][REM_W-1] ? (fin_mag <= fin_lim + REM_W'(1))
                                              : (rem_s[STAGES] <= fin_lim)));

endmodule

// File: tb/tb_sqrt_pipe.sv
module tb_sqrt_pipe;

    localparam int PERIOD = 10;
    localparam int LAT    = 18;
    localparam int RING   = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [17:0] out_root;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    bit exp_v [RING];
    int exp_r [RING];
    string exp_tag [RING];

    sqrt_pipe dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_root(out_root)
    );

    always #(PERIOD/2) clk = ~clk;

    // largest r with r*r <= x * 2^20, by binary search
    function automatic int ref_root(int x);
        longint t = longint'(x) << 20;
        longint lo = 0;
        longint hi = 1 << 19;
        while (lo < hi) begin
            longint mid = (lo + hi + 1) / 2;
            if (mid * mid <= t) lo = mid;
            else hi = mid - 1;
        end
        return int'(lo);
    endfunction

    task automatic clear_ring();
        for (int i = 0; i < RING; i++) begin
            exp_v[i] = 1'b0;
            exp_r[i] = 0;
            exp_tag[i] = "R4";
        end
    endtask

    // one cycle: check this cycle's outputs, then present the next input
    task automatic step(bit v, int d, string tag);
        int slot;
        int nxt;
        @(negedge clk);
        slot = cyc % RING;
        checks++;
        if (out_valid !== exp_v[slot]) begin
            errors++;
            $display("FAIL %s out_valid act %0b exp %0b (cycle %0d)", exp_tag[slot], out_valid, exp_v[slot], cyc);
        end else if (exp_v[slot]) begin
            checks++;
            if (int'(out_root) != exp_r[slot]) begin
                errors++;
                $display("FAIL %s out_root act %0d exp %0d", exp_tag[slot], out_root, exp_r[slot]);
            end
        end
        exp_v[slot] = 1'b0;
        exp_tag[slot] = "R4";
        nxt = (cyc + LAT) % RING;
        exp_v[nxt] = v;
        exp_r[nxt] = v ? ref_root(d) : 0;
        exp_tag[nxt] = v ? tag : "R4";
        in_valid = v;
        in_data = 16'(d);
        cyc++;
    endtask

    task automatic drain(string tag);
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 0, tag);
    endtask

    // R5: reset held with in_valid high; out_valid stays low
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_data = 16'd4321;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R5 out_valid in reset act %0b exp 0", out_valid);
            end
        end
        rst = 1'b0;
        in_valid = 1'b0;
        clear_ring();
        drain("R5");
    endtask

    // R6: fixed corner operands, plus their expected constants
    task automatic t_corners();
        checks++;
        if (ref_root(0) != 0 || ref_root(1) != 1024 || ref_root(65535) != 262141) begin
            errors++;
            $display("FAIL R6 reference act %0d/%0d/%0d exp 0/1024/262141",
                     ref_root(0), ref_root(1), ref_root(65535));
        end
        step(1'b1, 0, "R6");
        step(1'b1, 1, "R6");
        step(1'b1, 65535, "R6");
        step(1'b1, 2, "R6");
        step(1'b1, 65534, "R6");
        drain("R6");
    endtask

    // R2: one lone operand, every other cycle must stay idle
    task automatic t_latency();
        step(1'b1, 12345, "R2");
        drain("R2");
    endtask

    // R7: every perfect square, back to back
    task automatic t_squares();
        for (int k = 0; k < 256; k++) step(1'b1, k * k, "R7");
        drain("R7");
    endtask

    // R4: alternating bubbles and operands
    task automatic t_bubbles();
        for (int i = 0; i < 40; i++) step(i % 3 != 0, 1000 + 97 * i, "R4");
        drain("R4");
    endtask

    // R1 / R3: long back-to-back random stream
    task automatic t_random();
        for (int i = 0; i < 400; i++) step(1'b1, int'($urandom_range(0, 65535)), "R3");
        drain("R1");
    endtask

    // R5: reset while the pipe is full; nothing in flight may emerge
    task automatic t_midreset();
        for (int i = 0; i < 10; i++) step(1'b1, 500 + i, "R5");
        t_reset();
        step(1'b1, 169, "R5");
        drain("R5");
    endtask

    initial begin
        clear_ring();
        t_reset();
        t_corners();
        t_latency();
        t_squares();
        t_bubbles();
        t_random();
        t_midreset();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule